// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block holds the 64-bit base/enable control word of a per-core interrupt controller and drives everything that depends on it. The word carries a relocatable 4 KiB page address, a boot-core flag, a global enable and an extended-mode flag. Together the two flags select one of three operating modes: off, legacy or extended. Every write to the control word is screened. A write with a reserved bit set, with an impossible flag pair, or that would take a forbidden step between modes is refused and answered with a fault pulse. All other writes are applied.

Three side effects follow the mode. A memory-mapped window at the current base page serves the identity, version, priority and spurious-vector registers, and only in legacy mode. A separate register path serves the identity and spurious-vector registers, and only in extended mode. A 4-bit priority port works in every mode, and its value is shown in the memory-mapped priority register. Leaving a live mode for the off state puts the spurious-vector register and the identity back to their reset values.

Top module: `ictl_base_mode`

## Requirements
- R1: After reset the control word reads the page of RESET_BASE in bits [PA_WIDTH-1:12], 1 in bit 11 (enable), 0 in bit 10 (extended), BOOT_CORE in bit 8 and 0 elsewhere. The mode is legacy, the identity is INIT_ID, the spurious vector is 0x0FF and the priority is 0.
- R2: A control-word write that is accepted becomes visible on base_rdata, mode and base_addr one cycle later. A write that is refused raises base_fault for exactly the following cycle and leaves the control word unchanged.
- R3: A write that sets any bit in [7:0], bit 9, or any bit at or above PA_WIDTH is refused.
- R4: A write with bit 10 set and bit 11 clear is refused. A write with bit 10 set while ext_capable is 0 is refused.
- R5: mode encodes off as 0, legacy as 1 and extended as 2. A write that moves the mode from off to extended is refused, and so is a write from extended to legacy. Every other move is accepted, including a write that keeps the current mode.
- R6: A window read hits when mm_addr[PA_WIDTH-1:12] equals the current base page, so the window follows relocation. mm_hit and mm_rdata are valid in the cycle after mm_rd_en. A miss, or a cycle with no read, gives mm_hit 0 and mm_rdata 0.
- R7: In legacy mode the window serves these offsets: offset 0x020 holds the identity in bits [31:24], and it is writable. Offset 0x030 holds VERSION in bits [7:0]. Offset 0x080 holds the priority in bits [7:4]. Offset 0x0F0 holds the spurious vector in bits [8:0], and it is writable. Every other offset reads 0.
- R8: In the off mode and in extended mode, window reads that hit return 0xFFFFFFFF, and window writes change nothing.
- R9: A prio_wr_en write sets the priority in any mode. A legacy window write to offset 0x080 sets it from bits [7:4]. When both happen in the same cycle, the port wins. prio_rdata shows the priority.
- R10: The extended path is combinational from state. In extended mode xr_rdata returns the identity zero-extended when xr_sel is 0, and the spurious vector when xr_sel is 1. In other modes it returns all ones. A write with xr_sel 0 faults, and so does any write outside extended mode. An extended-mode write with xr_sel 1 sets the spurious vector. xr_fault follows the write by one cycle.
- R11: An accepted write that moves the mode from legacy or extended to off restores the spurious vector to 0x0FF and the identity to INIT_ID. The priority keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_capable | input | 1 | Extended mode may be entered |
| base_wr_en | input | 1 | Control-word write strobe |
| base_wdata | input | 64 | Control-word write value |
| base_fault | output | 1 | Refused control-word write (one cycle later) |
| base_rdata | output | 64 | Current control word |
| mode | output | 2 | 0 off, 1 legacy, 2 extended |
| base_addr | output | PA_WIDTH | Window base address |
| prio_wr_en | input | 1 | Priority port write strobe |
| prio_wdata | input | 4 | Priority port value |
| prio_rdata | output | 4 | Current priority |
| mm_rd_en | input | 1 | Window read strobe |
| mm_wr_en | input | 1 | Window write strobe |
| mm_addr | input | PA_WIDTH | Window access address |
| mm_wdata | input | 32 | Window write data |
| mm_hit | output | 1 | Registered read hit the window |
| mm_rdata | output | 32 | Registered window read data |
| xr_wr_en | input | 1 | Extended path write strobe |
| xr_sel | input | 1 | Extended path select: 0 identity, 1 spurious vector |
| xr_wdata | input | 9 | Extended path write data |
| xr_fault | output | 1 | Refused extended path write (one cycle later) |
| xr_rdata | output | 32 | Extended path read data |

## Verification
Every write (control word, window, priority and extended path) changes the state at the next clock edge. The write faults and the window read result also appear one edge after their strobe, while xr_rdata follows the current state and xr_sel in the same cycle. The bench drives stimulus just after a rising edge and keeps a behavioural reference that steps at the same rising edge. It compares every output at the falling edge that follows, so each one-cycle result is sampled exactly in the cycle it is due. Mode-transition sequences, relocation and reads at the old and new base page are run through that same per-cycle comparison.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_LEG = 2'd1,
        MODE_EXT = 2'd2
    } ictl_mode_e;

    localparam int EN_BIT   = 11;
    localparam int EXT_BIT  = 10;
    localparam int BOOT_BIT = 8;
    localparam int PAGE_LSB = 12;

    localparam logic [11:0] OFS_ID   = 12'h020;
    localparam logic [11:0] OFS_VER  = 12'h030;
    localparam logic [11:0] OFS_PRIO = 12'h080;
    localparam logic [11:0] OFS_SPUR = 12'h0F0;

    localparam logic [8:0] SPUR_RST = 9'h0FF;

    function automatic ictl_mode_e mode_of(input logic en, input logic ext);
        if (!en)
            return MODE_OFF;
        else if (ext)
            return MODE_EXT;
        else
            return MODE_LEG;
    endfunction

endpackage

// File: rtl/ictl_wr_check.sv
module ictl_wr_check
    import ictl_pkg::*;
#(
    parameter int PA_WIDTH = 36
)(
    input  ictl_mode_e  cur_mode,
    input  logic [63:0] wdata,
    input  logic        ext_capable,
    output logic        bad,
    output ictl_mode_e  nxt_mode
);
    localparam logic [63:0] ADDR_MASK = ((64'd1 << PA_WIDTH) - 64'd1) & ~64'hFFF;
    localparam logic [63:0] CTRL_MASK = (64'd1 << EN_BIT) | (64'd1 << EXT_BIT) | (64'd1 << BOOT_BIT);
    localparam logic [63:0] RSVD_MASK = ~(ADDR_MASK | CTRL_MASK);

    logic rsvd_hit, bad_pair, no_cap, bad_path;

    always_comb begin
        nxt_mode = mode_of(wdata[EN_BIT], wdata[EXT_BIT]);
        rsvd_hit = |(wdata & RSVD_MASK);
        bad_pair = wdata[EXT_BIT] & ~wdata[EN_BIT];
        no_cap   = wdata[EXT_BIT] & ~ext_capable;
        bad_path = ((cur_mode == MODE_OFF) && (nxt_mode == MODE_EXT)) ||
                   ((cur_mode == MODE_EXT) && (nxt_mode == MODE_LEG));
        bad      = rsvd_hit | bad_pair | no_cap | bad_path;
    end
endmodule

// File: rtl/ictl_mmio_dec.sv
module ictl_mmio_dec
    import ictl_pkg::*;
#(
    parameter int          PA_WIDTH = 36,
    parameter logic [7:0]  VERSION  = 8'h14
)(
    input  logic [PA_WIDTH-1:0]  mm_addr,
    input  logic [PA_WIDTH-13:0] page,
    input  ictl_mode_e           cur_mode,
    input  logic [7:0]           id,
    input  logic [8:0]           spur,
    input  logic [3:0]           prio,
    input  logic                 mm_wr_en,
    output logic                 hit,
    output logic [31:0]          rdata,
    output logic                 id_we,
    output logic                 spur_we,
    output logic                 prio_we
);
    logic [11:0] ofs;
    logic        open_win;

    always_comb begin
        ofs      = mm_addr[PAGE_LSB-1:0];
        hit      = (mm_addr[PA_WIDTH-1:PAGE_LSB] == page);
        open_win = hit && (cur_mode == MODE_LEG);

        if (!hit)
            rdata = 32'h0;
        else if (!open_win)
            rdata = 32'hFFFF_FFFF;
        else begin
            case (ofs)
                OFS_ID:   rdata = {id, 24'h0};
                OFS_VER:  rdata = {24'h0, VERSION};
                OFS_PRIO: rdata = {24'h0, prio, 4'h0};
                OFS_SPUR: rdata = {23'h0, spur};
                default:  rdata = 32'h0;
            endcase
        end

        id_we   = open_win && mm_wr_en && (ofs == OFS_ID);
        spur_we = open_win && mm_wr_en && (ofs == OFS_SPUR);
        prio_we = open_win && mm_wr_en && (ofs == OFS_PRIO);
    end
endmodule

// File: rtl/ictl_xreg.sv
module ictl_xreg
    import ictl_pkg::*;
(
    input  ictl_mode_e  cur_mode,
    input  logic        sel,
    input  logic [7:0]  id,
    input  logic [8:0]  spur,
    output logic        bad,
    output logic [31:0] rdata
);
    always_comb begin
        bad = (cur_mode != MODE_EXT) || !sel;
        if (cur_mode != MODE_EXT)
            rdata = 32'hFFFF_FFFF;
        else if (sel)
            rdata = {23'h0, spur};
        else
            rdata = {24'h0, id};
    end
endmodule

// File: rtl/ictl_base_mode.sv
module ictl_base_mode
    import ictl_pkg::*;
#(
    parameter int          PA_WIDTH   = 36,
    parameter logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000,
    parameter logic [7:0]  VERSION    = 8'h14,
    parameter logic [7:0]  INIT_ID    = 8'h03,
    parameter bit          BOOT_CORE  = 1'b1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_capable,
    input  logic                base_wr_en,
    input  logic [63:0]         base_wdata,
    output logic                base_fault,
    output logic [63:0]         base_rdata,
    output logic [1:0]          mode,
    output logic [PA_WIDTH-1:0] base_addr,
    input  logic                prio_wr_en,
    input  logic [3:0]          prio_wdata,
    output logic [3:0]          prio_rdata,
    input  logic                mm_rd_en,
    input  logic                mm_wr_en,
    input  logic [PA_WIDTH-1:0] mm_addr,
    input  logic [31:0]         mm_wdata,
    output logic                mm_hit,
    output logic [31:0]         mm_rdata,
    input  logic                xr_wr_en,
    input  logic                xr_sel,
    input  logic [8:0]          xr_wdata,
    output logic                xr_fault,
    output logic [31:0]         xr_rdata
);
    localparam int PG_W = PA_WIDTH - PAGE_LSB;

    typedef struct packed {
        logic            en;
        logic            ext;
        logic            boot;
        logic [PG_W-1:0] page;
        logic [7:0]      id;
        logic [8:0]      spur;
        logic [3:0]      prio;
        logic            bfault;
        logic            xfault;
        logic            mhit;
        logic [31:0]     mrdata;
    } st_t;

    st_t        s_d, s_q;
    ictl_mode_e mode_q;
    ictl_mode_e wr_next;
    logic       wr_bad;
    logic       win_hit;
    logic [31:0] win_rdata;
    logic       id_we, spur_we, prio_we;
    logic       xr_bad;

    assign mode_q = mode_of(s_q.en, s_q.ext);

    ictl_wr_check #(.PA_WIDTH(PA_WIDTH)) chk_i (
        .cur_mode    (mode_q),
        .wdata       (base_wdata),
        .ext_capable (ext_capable),
        .bad         (wr_bad),
        .nxt_mode    (wr_next)
    );

    ictl_mmio_dec #(.PA_WIDTH(PA_WIDTH), .VERSION(VERSION)) dec_i (
        .mm_addr  (mm_addr),
        .page     (s_q.page),
        .cur_mode (mode_q),
        .id       (s_q.id),
        .spur     (s_q.spur),
        .prio     (s_q.prio),
        .mm_wr_en (mm_wr_en),
        .hit      (win_hit),
        .rdata    (win_rdata),
        .id_we    (id_we),
        .spur_we  (spur_we),
        .prio_we  (prio_we)
    );

    ictl_xreg xr_i (
        .cur_mode (mode_q),
        .sel      (xr_sel),
        .id       (s_q.id),
        .spur     (s_q.spur),
        .bad      (xr_bad),
        .rdata    (xr_rdata)
    );

    always_comb begin
        s_d        = s_q;
        s_d.bfault = 1'b0;
        s_d.xfault = xr_wr_en & xr_bad;
        s_d.mhit   = mm_rd_en & win_hit;
        s_d.mrdata = mm_rd_en ? win_rdata : 32'h0;

        if (id_we)
            s_d.id = mm_wdata[31:24];
        if (spur_we)
            s_d.spur = mm_wdata[8:0];
        if (xr_wr_en && !xr_bad)
            s_d.spur = xr_wdata;
        if (prio_we)
            s_d.prio = mm_wdata[7:4];
        if (prio_wr_en)
            s_d.prio = prio_wdata;

        if (base_wr_en) begin
            if (wr_bad) begin
                s_d.bfault = 1'b1;
            end else begin
                s_d.en   = base_wdata[EN_BIT];
                s_d.ext  = base_wdata[EXT_BIT];
                s_d.boot = base_wdata[BOOT_BIT];
                s_d.page = base_wdata[PA_WIDTH-1:PAGE_LSB];
                if ((wr_next == MODE_OFF) && (mode_q != MODE_OFF)) begin
                    s_d.spur = SPUR_RST;
                    s_d.id   = INIT_ID;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.en   <= 1'b1;
            s_q.boot <= BOOT_CORE;
            s_q.page <= RESET_BASE[PA_WIDTH-1:PAGE_LSB];
            s_q.id   <= INIT_ID;
            s_q.spur <= SPUR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        base_rdata                          = 64'h0;
        base_rdata[PA_WIDTH-1:PAGE_LSB]     = s_q.page;
        base_rdata[EN_BIT]                  = s_q.en;
        base_rdata[EXT_BIT]                 = s_q.ext;
        base_rdata[BOOT_BIT]                = s_q.boot;
    end

    assign base_addr  = {s_q.page, {PAGE_LSB{1'b0}}};
    assign mode       = mode_q;
    assign base_fault = s_q.bfault;
    assign prio_rdata = s_q.prio;
    assign mm_hit     = s_q.mhit;
    assign mm_rdata   = s_q.mrdata;
    assign xr_fault   = s_q.xfault;

    // R2
    fault_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_fault |-> $stable(base_rdata));

    // R5
    no_off_to_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_OFF) |-> (mode_q != MODE_EXT));

    // R5
    no_ext_to_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_EXT) |-> (mode_q != MODE_LEG));

    // R4
    ext_needs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_EXT) && ($past(mode_q) != MODE_EXT)) |-> $past(ext_capable));

    // R11
    off_entry_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_OFF) && ($past(mode_q) != MODE_OFF)) |-> (s_q.spur == SPUR_RST));

    // R10
    xid_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_wr_en && !xr_sel) |=> xr_fault);

    // R8
    closed_window_keeps_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_wr_en && (mode_q != MODE_LEG) && !base_wr_en) |=> $stable(s_q.id));

endmodule

// File: tb/ictl_base_mode_tb_top.sv
`timescale 1ns/1ps
module ictl_base_mode_tb_top;
    localparam int          PA   = 36;
    localparam logic [7:0]  VER  = 8'h14;
    localparam logic [7:0]  IID  = 8'h03;
    localparam longint unsigned BASE0 = 64'hFEE0_0000;
    localparam longint unsigned BASE1 = 64'hFED4_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_capable = 1'b1;
    logic          base_wr_en = 1'b0;
    logic [63:0]   base_wdata = '0;
    logic          base_fault;
    logic [63:0]   base_rdata;
    logic [1:0]    mode;
    logic [PA-1:0] base_addr;
    logic          prio_wr_en = 1'b0;
    logic [3:0]    prio_wdata = '0;
    logic [3:0]    prio_rdata;
    logic          mm_rd_en = 1'b0;
    logic          mm_wr_en = 1'b0;
    logic [PA-1:0] mm_addr = '0;
    logic [31:0]   mm_wdata = '0;
    logic          mm_hit;
    logic [31:0]   mm_rdata;
    logic          xr_wr_en = 1'b0;
    logic          xr_sel = 1'b0;
    logic [8:0]    xr_wdata = '0;
    logic          xr_fault;
    logic [31:0]   xr_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ictl_base_mode #(.PA_WIDTH(PA), .VERSION(VER), .INIT_ID(IID), .BOOT_CORE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_capable(ext_capable),
        .base_wr_en(base_wr_en), .base_wdata(base_wdata), .base_fault(base_fault),
        .base_rdata(base_rdata), .mode(mode), .base_addr(base_addr),
        .prio_wr_en(prio_wr_en), .prio_wdata(prio_wdata), .prio_rdata(prio_rdata),
        .mm_rd_en(mm_rd_en), .mm_wr_en(mm_wr_en), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_hit(mm_hit), .mm_rdata(mm_rdata),
        .xr_wr_en(xr_wr_en), .xr_sel(xr_sel), .xr_wdata(xr_wdata),
        .xr_fault(xr_fault), .xr_rdata(xr_rdata)
    );

    // Behavioural reference
    bit              m_en, m_ext, m_boot, m_bf, m_xf, m_hit;
    longint unsigned m_page;
    int unsigned     m_id, m_spur, m_prio, m_rd;

    function automatic int mmode();
        if (!m_en) return 0;
        return m_ext ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        int cm, nm, ofs;
        bit bad, win;
        longint unsigned w;
        if (!rst_n) begin
            m_en = 1; m_ext = 0; m_boot = 1; m_page = BASE0 >> 12;
            m_id = IID; m_spur = 'h0FF; m_prio = 0;
            m_bf = 0; m_xf = 0; m_hit = 0; m_rd = 0;
        end else begin
            cm  = mmode();
            ofs = int'(mm_addr[11:0]);
            win = ((longint'(mm_addr) >> 12) == m_page);
            m_hit = mm_rd_en && win;
            m_rd  = 0;
            if (m_hit) begin
                if (cm != 1) m_rd = 32'hFFFF_FFFF;
                else if (ofs == 'h20) m_rd = m_id << 24;
                else if (ofs == 'h30) m_rd = VER;
                else if (ofs == 'h80) m_rd = m_prio << 4;
                else if (ofs == 'hF0) m_rd = m_spur;
            end
            if (mm_wr_en && win && cm == 1) begin
                if (ofs == 'h20) m_id = mm_wdata[31:24];
                if (ofs == 'hF0) m_spur = mm_wdata[8:0];
                if (ofs == 'h80) m_prio = mm_wdata[7:4];
            end
            m_xf = xr_wr_en && !(cm == 2 && xr_sel);
            if (xr_wr_en && !m_xf) m_spur = xr_wdata;
            if (prio_wr_en) m_prio = prio_wdata;
            m_bf = 0;
            if (base_wr_en) begin
                w = base_wdata;
                bad = 0;
                for (int b = 0; b < 64; b++)
                    if (w[b] && !(b == 8 || b == 10 || b == 11 || (b >= 12 && b < PA))) bad = 1;
                if (w[10] && !w[11]) bad = 1;
                if (w[10] && !ext_capable) bad = 1;
                nm = !w[11] ? 0 : (w[10] ? 2 : 1);
                if (cm == 0 && nm == 2) bad = 1;
                if (cm == 2 && nm == 1) bad = 1;
                if (bad) m_bf = 1;
                else begin
                    m_en = w[11]; m_ext = w[10]; m_boot = w[8]; m_page = (w & ((64'd1 << PA) - 1)) >> 12;
                    if (nm == 0 && cm != 0) begin m_spur = 'h0FF; m_id = IID; end
                end
            end
        end
    end

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        longint unsigned eb, ex;
        if (rst_n && !done) begin
            eb = (m_page << 12) | (longint'(m_en) << 11) | (longint'(m_ext) << 10) | (longint'(m_boot) << 8);
            chk("R2 control word", base_rdata, eb);
            chk("R5 mode", mode, mmode());
            chk("R6 base_addr", base_addr, m_page << 12);
            chk("R3 R4 R5 base_fault", base_fault, m_bf);
            chk("R9 priority", prio_rdata, m_prio);
            chk("R6 mm_hit", mm_hit, m_hit);
            chk("R7 R8 R11 mm_rdata", mm_rdata, m_rd);
            ex = (mmode() != 2) ? 64'hFFFF_FFFF : (xr_sel ? m_spur : m_id);
            chk("R10 xr_rdata", xr_rdata, ex);
            chk("R10 xr_fault", xr_fault, m_xf);
        end
    end

    task automatic step();
        @(posedge clk); #1;
        base_wr_en = 0; mm_rd_en = 0; mm_wr_en = 0; xr_wr_en = 0; prio_wr_en = 0;
    endtask
    task automatic wr_base(longint unsigned v);
        @(posedge clk); #1; base_wr_en = 1; base_wdata = v; step();
    endtask
    task automatic rd_mm(longint unsigned a);
        @(posedge clk); #1; mm_rd_en = 1; mm_addr = a[PA-1:0]; step();
    endtask
    task automatic wr_mm(longint unsigned a, logic [31:0] d);
        @(posedge clk); #1; mm_wr_en = 1; mm_addr = a[PA-1:0]; mm_wdata = d; step();
    endtask
    task automatic wr_xr(logic s, logic [8:0] d);
        @(posedge clk); #1; xr_wr_en = 1; xr_sel = s; xr_wdata = d; step();
    endtask
    task automatic wr_prio(logic [3:0] d);
        @(posedge clk); #1; prio_wr_en = 1; prio_wdata = d; step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state, against fixed constants
        chk("R1 reset word", base_rdata, 64'hFEE0_0900);
        chk("R1 reset mode", mode, 1);
        chk("R1 reset priority", prio_rdata, 0);
        // R7 legacy window reads, R6 miss
        rd_mm(BASE0 + 'h20); rd_mm(BASE0 + 'h30); rd_mm(BASE0 + 'h80);
        rd_mm(BASE0 + 'hF0); rd_mm(BASE0 + 'h40); rd_mm(BASE1 + 'h30);
        step();
        // R7 window writes, R9 priority paths
        wr_mm(BASE0 + 'h20, 32'h5A00_0000); rd_mm(BASE0 + 'h20);
        wr_mm(BASE0 + 'hF0, 32'h0000_01FF); rd_mm(BASE0 + 'hF0);
        wr_mm(BASE0 + 'h80, 32'h0000_00C0); rd_mm(BASE0 + 'h80);
        wr_prio(4'h9); rd_mm(BASE0 + 'h80);
        // R10 extended path outside extended mode
        wr_xr(1'b1, 9'h1AA); xr_sel = 0; step();
        // R3 reserved bits
        wr_base(BASE0 | 'h801); wr_base(BASE0 | 'hA00);
        wr_base(BASE0 | 'h800 | (64'd1 << PA)); wr_base(BASE0 | 'h800 | (64'd1 << 63));
        // R4 bad pair and no capability
        wr_base(BASE0 | 'h400);
        ext_capable = 0; wr_base(BASE0 | 'hC00); ext_capable = 1;
        // R5 legacy to extended, same-mode write
        wr_base(BASE0 | 'hD00); wr_base(BASE0 | 'hD00);
        // R8 closed window
        rd_mm(BASE0 + 'h30); wr_mm(BASE0 + 'h20, 32'h7700_0000);
        // R10 extended path
        xr_sel = 0; step(); xr_sel = 1; step();
        wr_xr(1'b0, 9'h012); wr_xr(1'b1, 9'h13C); step();
        // R9 priority port in extended mode
        wr_prio(4'h3);
        // R5 extended to legacy refused, to off accepted, R11 resets
        wr_base(BASE0 | 'h900); wr_base(BASE0 | 'h100);
        rd_mm(BASE0 + 'hF0); wr_mm(BASE0 + 'hF0, 32'h0);
        // R5 off to extended refused
        wr_base(BASE0 | 'hD00);
        // R6 relocation on off to legacy
        wr_base(BASE1 | 'h800);
        rd_mm(BASE1 + 'h30); rd_mm(BASE0 + 'h30); rd_mm(BASE1 + 'hF0); rd_mm(BASE1 + 'h20);
        wr_mm(BASE1 + 'hF0, 32'h0000_01FF); rd_mm(BASE1 + 'hF0);
        // R11 legacy to off restores identity
        wr_mm(BASE1 + 'h20, 32'h4400_0000); wr_base(BASE1);
        wr_base(BASE1 | 'h800); rd_mm(BASE1 + 'h20);
        // R9 simultaneous port and window priority write
        @(posedge clk); #1; prio_wr_en = 1; prio_wdata = 4'h6; mm_wr_en = 1;
        mm_addr = BASE1[PA-1:0] + 'h80; mm_wdata = 32'h0000_00E0; step();
        rd_mm(BASE1 + 'h80);
        repeat (3) step();
        finish_run();
    end
endmodule